// File: doc/BRIEF.md
# S/PDIF Subframe Status Bit Sequencer

This block builds the 32-slot subframe words that a biphase-mark line coder serializes onto an S/PDIF link. Audio samples arrive one per subframe over a valid/ready port, alternating channel A then channel B. For each sample the block attaches the validity, user and channel status bits, adds an even parity bit, and writes a preamble type code into the first four slots. It also tracks where each 192-frame block begins.

A control bit selects the source of the side bits. In stream mode every sample brings its own validity, user, status and block-start flag, and the block copies them into the word. In register mode only the audio is taken from the sample. Validity comes from two control bits, channel status from two persistent 192-bit buffers, and user bits from two 192-bit buffers. The user buffers are copied to a shadow at each block start, so software can load the next block's user data while the current block plays. Software should program the buffers and mode first, and set the enable last or in the same write.

Top module: `spdif_sub_seq`

## Requirements
- R1: After reset the enable is clear, `in_ready_o` is 0 and `out_valid_o` is 0.
- R2: Output word layout: bits 3:0 hold the preamble code (1 = block start, 2 = channel A, 3 = channel B), bits 27:4 the audio sample (LSB at bit 4), bit 28 validity, bit 29 user, bit 30 channel status, bit 31 parity.
- R3: Bits 31:4 of every output word have even parity.
- R4: Accepted samples are assigned to channel A and channel B in turn, starting with A after enable. In register mode the A subframe of frame 0 of each 192-frame block carries code 1, other A subframes carry code 2, and every B subframe carries code 3.
- R5: In stream mode (control bit 9 = 0) validity, user and status bits are copied from `in_vbit_i`, `in_user_i` and `in_cstat_i`. An A subframe whose `in_blk_i` is 1 gets code 1. `in_blk_i` on a B subframe is ignored.
- R6: In register mode the status bit of frame n is bit n of that channel's status buffer, where bit n sits in word n/32, bit n%32. Channel A words are at addresses 0x08 to 0x0D and channel B words at 0x10 to 0x15. The same values are used for every block.
- R7: In register mode the validity of A comes from control bit 10 and of B from bit 11. The sample's validity, user, status and block-start inputs have no effect.
- R8: User buffers are at 0x18 to 0x1D (A) and 0x20 to 0x25 (B), using the same bit numbering as R6. Their contents are taken at the A subframe of frame 0. Writes made during a block apply from the next block on, and unchanged buffers repeat.
- R9: Control bit 0 (address 0x00) is the enable. While it is 0, `in_ready_o` is 0 and the frame position is cleared, so the first subframe after re-enable is the A subframe of frame 0.
- R10: `in_ready_o` is 1 when enabled and the output register is empty or being drained. A word held with `out_ready_i` low stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Sample accepted this cycle when valid |
| in_audio_i | input | 24 | Audio sample |
| in_vbit_i | input | 1 | Validity bit (stream mode) |
| in_user_i | input | 1 | User bit (stream mode) |
| in_cstat_i | input | 1 | Channel status bit (stream mode) |
| in_blk_i | input | 1 | Block start flag (stream mode) |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word taken |
| out_word_o | output | 32 | Assembled subframe word |

## Verification
The hardest case to reach is a user buffer write that lands in the middle of a block. It has to leave the rest of that block alone and take effect only at the next block start, which is 384 accepted subframes away. The bench streams more than two full blocks in register mode and rewrites user words partway through the first block. It then compares every word of both blocks against a model that keeps its own shadow copy. Random stalls on `out_ready_i` run throughout, so the held-word path and the handshake are exercised as well.

// File: rtl/spdif_seq_pkg.sv
package spdif_seq_pkg;
  localparam int unsigned BLK_FRAMES = 192;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned AUDIO_W    = 24;
  localparam int unsigned ADDR_W     = 6;
  localparam int unsigned BUF_WORDS  = BLK_FRAMES / WORD_W;
  localparam int unsigned FR_W       = $clog2(BLK_FRAMES);

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CSA  = 8;
  localparam int unsigned A_CSB  = 16;
  localparam int unsigned A_USA  = 24;
  localparam int unsigned A_USB  = 32;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_MODE = 9;
  localparam int unsigned B_VA   = 10;
  localparam int unsigned B_VB   = 11;

  typedef enum logic [3:0] {
    PRE_NONE = 4'd0,
    PRE_BLK  = 4'd1,
    PRE_CHA  = 4'd2,
    PRE_CHB  = 4'd3
  } pre_e;

  typedef struct packed {
    logic [AUDIO_W-1:0] audio;
    logic               vbit;
    logic               user;
    logic               cstat;
    logic               blk;
  } sample_t;
endpackage

// File: rtl/spdif_seq_regs.sv
module spdif_seq_regs
  import spdif_seq_pkg::*;
#(
  parameter int unsigned FRAMES = BLK_FRAMES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 latch_i,
  output logic                 en_o,
  output logic                 standalone_o,
  output logic                 val_a_o,
  output logic                 val_b_o,
  output logic [FRAMES-1:0]    cs_a_o,
  output logic [FRAMES-1:0]    cs_b_o,
  output logic [FRAMES-1:0]    us_a_o,
  output logic [FRAMES-1:0]    us_b_o,
  output logic [FRAMES-1:0]    sh_a_o,
  output logic [FRAMES-1:0]    sh_b_o
);
  localparam int unsigned NW = FRAMES / WORD_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o         <= 1'b0;
      standalone_o <= 1'b0;
      val_a_o      <= 1'b0;
      val_b_o      <= 1'b0;
    end else if (we_i && addr_i == ADDR_W'(A_CTRL)) begin
      en_o         <= wdata_i[B_EN];
      standalone_o <= wdata_i[B_MODE];
      val_a_o      <= wdata_i[B_VA];
      val_b_o      <= wdata_i[B_VB];
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cs_a_o[k*WORD_W +: WORD_W] <= '0;
        cs_b_o[k*WORD_W +: WORD_W] <= '0;
        us_a_o[k*WORD_W +: WORD_W] <= '0;
        us_b_o[k*WORD_W +: WORD_W] <= '0;
      end else if (we_i) begin
        if (addr_i == ADDR_W'(A_CSA + k)) cs_a_o[k*WORD_W +: WORD_W] <= wdata_i;
        if (addr_i == ADDR_W'(A_CSB + k)) cs_b_o[k*WORD_W +: WORD_W] <= wdata_i;
        if (addr_i == ADDR_W'(A_USA + k)) us_a_o[k*WORD_W +: WORD_W] <= wdata_i;
        if (addr_i == ADDR_W'(A_USB + k)) us_b_o[k*WORD_W +: WORD_W] <= wdata_i;
      end
    end
  end

  // shadow copy taken at block start; later writes wait for next block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a_o <= '0;
      sh_b_o <= '0;
    end else if (latch_i) begin
      sh_a_o <= us_a_o;
      sh_b_o <= us_b_o;
    end
  end
endmodule

// File: rtl/spdif_seq_pos.sv
module spdif_seq_pos
  import spdif_seq_pkg::*;
#(
  parameter int unsigned FRAMES = BLK_FRAMES,
  parameter int unsigned FW     = FR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          step_i,
  output logic          ch_b_o,
  output logic [FW-1:0] frame_o,
  output logic          blk_start_o
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_b_o  <= 1'b0;
      frame_o <= '0;
    end else if (!en_i) begin
      ch_b_o  <= 1'b0;
      frame_o <= '0;
    end else if (step_i) begin
      ch_b_o <= ~ch_b_o;
      if (ch_b_o) frame_o <= (frame_o == LAST) ? '0 : frame_o + 1'b1;
    end
  end

  assign blk_start_o = !ch_b_o && (frame_o == '0);
endmodule

// File: rtl/spdif_seq_fmt.sv
module spdif_seq_fmt
  import spdif_seq_pkg::*;
(
  input  sample_t           smp_i,
  input  logic              ch_b_i,
  input  logic              blk_start_i,
  input  logic              standalone_i,
  input  logic              reg_v_i,
  input  logic              reg_u_i,
  input  logic              reg_c_i,
  output logic [WORD_W-1:0] word_o
);
  pre_e pre;
  logic v, u, c;

  always_comb begin
    if (standalone_i) begin
      v = reg_v_i;
      u = reg_u_i;
      c = reg_c_i;
      if (ch_b_i)           pre = PRE_CHB;
      else if (blk_start_i) pre = PRE_BLK;
      else                  pre = PRE_CHA;
    end else begin
      v = smp_i.vbit;
      u = smp_i.user;
      c = smp_i.cstat;
      if (ch_b_i)         pre = PRE_CHB;
      else if (smp_i.blk) pre = PRE_BLK;
      else                pre = PRE_CHA;
    end
    word_o[3:0]              = pre;
    word_o[4 +: AUDIO_W]     = smp_i.audio;
    word_o[28]               = v;
    word_o[29]               = u;
    word_o[30]               = c;
    word_o[31]               = ^{c, u, v, smp_i.audio};
  end
endmodule

// File: rtl/spdif_sub_seq.sv
module spdif_sub_seq
  import spdif_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [AUDIO_W-1:0]  in_audio_i,
  input  logic                in_vbit_i,
  input  logic                in_user_i,
  input  logic                in_cstat_i,
  input  logic                in_blk_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [WORD_W-1:0]   out_word_o
);
  logic                  ctrl_en, ctrl_sa, ctrl_va, ctrl_vb;
  logic [BLK_FRAMES-1:0] cs_a, cs_b, us_a, us_b, sh_a, sh_b;
  logic                  ch_b, blk_start, accept;
  logic [FR_W-1:0]       frame;
  logic                  sel_v, sel_u, sel_c;
  logic [WORD_W-1:0]     word;
  sample_t               smp;

  assign in_ready_o = ctrl_en && (!out_valid_o || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  spdif_seq_regs u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .latch_i     (accept && blk_start),
    .en_o        (ctrl_en),
    .standalone_o(ctrl_sa),
    .val_a_o     (ctrl_va),
    .val_b_o     (ctrl_vb),
    .cs_a_o      (cs_a),
    .cs_b_o      (cs_b),
    .us_a_o      (us_a),
    .us_b_o      (us_b),
    .sh_a_o      (sh_a),
    .sh_b_o      (sh_b)
  );

  spdif_seq_pos u_pos (
    .clk_i, .rst_ni,
    .en_i       (ctrl_en),
    .step_i     (accept),
    .ch_b_o     (ch_b),
    .frame_o    (frame),
    .blk_start_o(blk_start)
  );

  // frame 0 of channel A reads the live buffer, the shadow is loaded on that same edge
  always_comb begin
    sel_v = ch_b ? ctrl_vb : ctrl_va;
    sel_c = ch_b ? cs_b[frame] : cs_a[frame];
    if (ch_b)           sel_u = sh_b[frame];
    else if (blk_start) sel_u = us_a[0];
    else                sel_u = sh_a[frame];
  end

  assign smp = '{audio: in_audio_i, vbit: in_vbit_i, user: in_user_i,
                 cstat: in_cstat_i, blk: in_blk_i};

  spdif_seq_fmt u_fmt (
    .smp_i       (smp),
    .ch_b_i      (ch_b),
    .blk_start_i (blk_start),
    .standalone_i(ctrl_sa),
    .reg_v_i     (sel_v),
    .reg_u_i     (sel_u),
    .reg_c_i     (sel_c),
    .word_o      (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      out_word_o  <= word;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spdif_sub_seq_chk.sv
module spdif_sub_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_word_o
);
  logic last_b;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_b <= 1'b0;
    else if (out_valid_o && out_ready_i) last_b <= (out_word_o[3:0] == 4'd3);
  end

  // R3
  parity_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (^out_word_o[31:4]) == 1'b0);

  // R2
  code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_word_o[3:0] != 4'd0 && out_word_o[3:0] <= 4'd3));

  // R10
  hold_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));

  // R9
  off_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !in_ready_o);

  // R4
  no_double_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_word_o[3:0] == 4'd3) |-> !last_b);
endmodule

bind spdif_sub_seq spdif_sub_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (ctrl_en),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_word_o (out_word_o)
);

// File: tb/spdif_sub_seq_test.sv
module spdif_sub_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [23:0] audio = '0;
  logic        vb = 1'b0, ub = 1'b0, cb = 1'b0, blk = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_word;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spdif_sub_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_audio_i(audio), .in_vbit_i(vb), .in_user_i(ub), .in_cstat_i(cb), .in_blk_i(blk),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_word_o(out_word)
  );

  // reference model state
  logic [31:0]  ctrl_m = '0;
  logic [191:0] csa_m = '0, csb_m = '0, ua_m = '0, ub_m = '0, sua_m = '0, sub_m = '0;
  int           fr_m = 0;
  bit           ch_m = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
    if (a == 6'd0) begin
      ctrl_m = d;
      if (!d[0]) begin fr_m = 0; ch_m = 1'b0; end
    end
    else if (a >= 6'd8  && a < 6'd14) csa_m[(a-8)*32  +: 32] = d;
    else if (a >= 6'd16 && a < 6'd22) csb_m[(a-16)*32 +: 32] = d;
    else if (a >= 6'd24 && a < 6'd30) ua_m[(a-24)*32  +: 32] = d;
    else if (a >= 6'd32 && a < 6'd38) ub_m[(a-32)*32  +: 32] = d;
  endtask

  function automatic logic [31:0] model(input logic [23:0] a, input logic v, u, c, b);
    logic [3:0] code;
    logic ev, eu, ec;
    if (!ch_m && fr_m == 0) begin sua_m = ua_m; sub_m = ub_m; end
    if (ctrl_m[9]) begin
      ev = ch_m ? ctrl_m[11] : ctrl_m[10];
      ec = ch_m ? csb_m[fr_m] : csa_m[fr_m];
      eu = ch_m ? sub_m[fr_m] : sua_m[fr_m];
      code = ch_m ? 4'd3 : (fr_m == 0 ? 4'd1 : 4'd2);
    end else begin
      ev = v; eu = u; ec = c;
      code = ch_m ? 4'd3 : (b ? 4'd1 : 4'd2);
    end
    if (ch_m) fr_m = (fr_m == 191) ? 0 : fr_m + 1;
    ch_m = ~ch_m;
    return {^{ec, eu, ev, a}, ec, eu, ev, a, code};
  endfunction

  task automatic send(input logic [23:0] a, input logic v, u, c, b, input string tag);
    @(negedge clk); #1;
    in_valid = 1'b1; audio = a; vb = v; ub = u; cb = c; blk = b;
    #0.5;
    while (!in_ready) begin @(negedge clk); #1.5; end
    @(posedge clk); #0.2;
    exp_q.push_back(model(a, v, u, c, b));
    tag_q.push_back(tag);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] held;
  bit          was_held = 1'b0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (lfsr[2:0] != 3'd0);
    #0.5;
    if (rst_n) begin
      if (was_held) check(out_valid && out_word == held, "R10 held word", out_word, held);
      was_held = out_valid && !out_ready;
      held = out_word;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected word", out_word, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word == e, t, out_word, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!in_ready, "R1 in_ready after reset", {31'b0, in_ready}, 32'h0);
    check(!out_valid, "R1 out_valid after reset", {31'b0, out_valid}, 32'h0);

    // stream mode: side bits from samples (R2 R3 R5)
    wr(6'd0, 32'h1);
    for (int i = 0; i < 24; i++)
      send(24'(i * 24'h13579B), i[0], i[1], i[2], (i % 6 == 0) || (i == 5),
           "R2 R3 R4 R5 stream word");

    // disable: no acceptance (R9)
    wr(6'd0, 32'h0);
    repeat (4) begin
      @(negedge clk); #0.5;
      check(!in_ready, "R9 ready while disabled", {31'b0, in_ready}, 32'h0);
    end
    repeat (10) @(posedge clk);

    // register mode setup, enable last (R6 R7 R8)
    for (int k = 0; k < 6; k++) begin
      wr(6'(8 + k),  32'hA5C3_0F96 ^ (32'h1111_1111 * k));
      wr(6'(16 + k), 32'h5A3C_F069 + (32'h0101_0303 * k));
      wr(6'(24 + k), 32'hDEAD_0000 | 32'(k * 77));
      wr(6'(32 + k), 32'h0BAD_F00D ^ 32'(k << 12));
    end
    wr(6'd0, 32'h0000_0601 & ~32'h400 | 32'h200 | 32'h400);
    for (int i = 0; i < 900; i++) begin
      send(24'(i * 24'h2F1D3), i[3], i[4], i[5], i[0], "R4 R6 R7 R8 register word");
      if (i == 100) begin
        // mid-block user rewrite, applies from next block
        wr(6'd25, 32'h1234_5678);
        wr(6'd34, 32'hFFFF_0000);
        wr(6'd24, 32'h0F0F_F0F0);
      end
    end

    // re-enable restarts block, validity swapped (R9 R7)
    wr(6'd0, 32'h0000_0000);
    wr(6'd0, 32'h0000_0A01);
    for (int i = 0; i < 12; i++)
      send(24'(i + 24'h800000), 1'b1, 1'b1, 1'b1, 1'b0, "R9 R4 R7 restart word");

    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule